// File: doc/BRIEF.md
# Fractional Clock Divider with Gating

This block derives a slower clock from a single reference clock. A phase accumulator of `FRAC_W` fraction bits adds a programmed step on every rising reference edge. Every time the sum crosses the integer boundary, the carry marks the following reference cycle as an output cycle. The block reports this as a one-cycle clock-enable strobe and also turns it into a glitch-free clock. Over any `2^FRAC_W` consecutive reference cycles the block produces exactly `step` output pulses.

A small mode controller picks the behaviour from the enable bit and the step field, and re-evaluates the choice at every rising edge. The states are:
- `MODE_HOLD`: entered on reset.
- `MODE_PASS`: bypass.
- `MODE_INT`: plain integer divide by `step`.
- `MODE_FRAC`: fractional, step below one half.
- `MODE_GATE`: per-cycle gating of the reference, step of one half or more.

Every state can move to any other state at the next edge. The target is set by the inputs alone, as follows:

| Enable | Step field | Next state |
|---|---|---|
| 0 | 0 or 1 | `MODE_PASS` |
| 0 | 2 or more | `MODE_INT` |
| 1 | top bit 0 | `MODE_FRAC` |
| 1 | top bit 1 | `MODE_GATE` |

Asserting reset forces `MODE_HOLD`.

The clock is formed in two ways. In fractional mode it is a falling-edge register, so each pulse lasts one full reference period and is shifted by half a period. In the gating modes a falling-edge enable is ANDed with the reference, so only whole reference high phases reach the output.

Top module: `frac_clk_div`

## Requirements
- R1: While `rst_n` is low, `clk_en` and `clk_out` are 0, and this holds immediately when reset is asserted in the middle of a cycle. The accumulator restarts from zero.
- R2: In fractional mode (`frac_en`=1, top bit of `div_step`=0), `clk_en` is high in the cycle after each rising edge at which accumulator + step ≥ 2^FRAC_W, the accumulator keeping the sum modulo 2^FRAC_W. Any 2^FRAC_W consecutive cycles hold exactly `div_step` strobes, and a step of 0 gives none.
- R3: In fractional mode, each `clk_out` pulse rises at the falling reference edge inside a `clk_en` cycle and lasts one full reference period.
- R4: In gated mode (`frac_en`=1, top bit of `div_step`=1), `clk_en` follows the same carry rule as R2. `clk_out` passes the reference high phase of the cycle that follows each strobe cycle and is low otherwise.
- R5: With a step of three quarters of 2^FRAC_W in gated mode, three of every four reference pulses pass and one is blocked. From reset the strobe pattern is 0,1,1,1.
- R6: With `frac_en`=0 and `div_step` ≥ 2, `clk_en` is high once every `div_step` cycles, first in the `div_step`-th cycle, and `clk_out` is the gated reference.
- R7: With `frac_en`=0 and `div_step` ≤ 1, `clk_en` stays high and `clk_out` follows the reference.
- R8: While `frac_en`=0 the accumulator is held at zero. After a switch to fractional mode, the first carry comes after ceil(2^FRAC_W/step) cycles.
- R9: A new `div_step` is added at the first rising edge after it is applied, with no glitch on `clk_out`.
- R10: In the gating modes every `clk_out` high pulse is exactly half a reference period, never narrower.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frac_en | input | 1 | 1 selects accumulator operation, 0 selects integer divide or bypass |
| div_step | input | FRAC_W | Fractional step (units of 2^-FRAC_W) or integer divisor |
| clk_en | output | 1 | One-cycle strobe marking each output cycle |
| clk_out | output | 1 | Glitch-free divided or gated clock |

## Verification
The bench tracks the carry sequence cycle by cycle against a model built from the requirements, so a design that registers the step one cycle late, or that keeps a stale accumulator after integer mode, shows a shifted strobe pattern. Pulse widths are measured in time. An AND gate driven by a rising-edge enable would leave runt or merged pulses, and a fractional path that lacks the half-cycle shift would give half-width pulses. Counts over full accumulator windows catch a wrong carry boundary (off-by-one in pulses per window). Asserting reset in the middle of a cycle exposes a gated output that is not cleared at once.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [2:0] {
        MODE_HOLD = 3'd0,
        MODE_PASS = 3'd1,
        MODE_INT  = 3'd2,
        MODE_FRAC = 3'd3,
        MODE_GATE = 3'd4
    } mode_e;

endpackage

// File: rtl/fcd_mode_ctrl.sv
module fcd_mode_ctrl
    import fcd_pkg::*;
#(
    parameter int FRAC_W = 8
) (
    input  logic              clk_ref,
    input  logic              rst_n,
    input  logic              frac_en,
    input  logic [FRAC_W-1:0] step,
    output mode_e             mode_nxt,
    output mode_e             mode_q,
    output logic              gate_path,
    output logic              shift_path
);

    localparam int MSB = FRAC_W - 1;

    logic step_small;
    assign step_small = (step <= FRAC_W'(1));

    // next-state: target is picked by the inputs from any state
    always_comb begin
        mode_nxt = MODE_HOLD;
        unique case (mode_q)
            MODE_HOLD, MODE_PASS, MODE_INT, MODE_FRAC, MODE_GATE: begin
                if (!frac_en) begin
                    mode_nxt = step_small ? MODE_PASS : MODE_INT;
                end else begin
                    mode_nxt = step[MSB] ? MODE_GATE : MODE_FRAC;
                end
            end
            default: mode_nxt = MODE_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_HOLD;
        end else begin
            mode_q <= mode_nxt;
        end
    end

    // outputs: which clock path the current state drives
    always_comb begin
        gate_path  = 1'b0;
        shift_path = 1'b0;
        unique case (mode_q)
            MODE_HOLD: ;
            MODE_PASS: gate_path  = 1'b1;
            MODE_INT:  gate_path  = 1'b1;
            MODE_FRAC: shift_path = 1'b1;
            MODE_GATE: gate_path  = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/fcd_phase.sv
module fcd_phase
    import fcd_pkg::*;
#(
    parameter int FRAC_W = 8
) (
    input  logic              clk_ref,
    input  logic              rst_n,
    input  mode_e             mode_nxt,
    input  mode_e             mode_q,
    input  logic [FRAC_W-1:0] step,
    output logic              strobe
);

    localparam int SUM_W = FRAC_W + 1;

    logic [FRAC_W-1:0] acc_q, acc_d;
    logic [FRAC_W-1:0] cnt_q, cnt_d;
    logic              strobe_q, strobe_d;
    logic [SUM_W-1:0]  sum;
    logic [FRAC_W-1:0] last_cnt;

    assign sum      = {1'b0, acc_q} + {1'b0, step};
    assign last_cnt = step - FRAC_W'(1);

    always_comb begin
        acc_d    = '0;
        cnt_d    = '0;
        strobe_d = 1'b0;
        unique case (mode_nxt)
            MODE_HOLD: ;
            MODE_PASS: strobe_d = 1'b1;
            MODE_INT: begin
                if (cnt_q >= last_cnt) begin
                    strobe_d = 1'b1;
                end else begin
                    cnt_d = cnt_q + FRAC_W'(1);
                end
            end
            MODE_FRAC, MODE_GATE: begin
                acc_d    = sum[FRAC_W-1:0];
                strobe_d = sum[FRAC_W];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            acc_q    <= '0;
            cnt_q    <= '0;
            strobe_q <= 1'b0;
        end else begin
            acc_q    <= acc_d;
            cnt_q    <= cnt_d;
            strobe_q <= strobe_d;
        end
    end

    assign strobe = strobe_q;

    // R8: accumulator stays at zero outside accumulator modes
    a_r8_acc_held_zero: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (mode_nxt == MODE_PASS || mode_nxt == MODE_INT) |=> (acc_q == '0));

    // R7: bypass strobes every cycle
    a_r7_pass_strobe: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (mode_nxt == MODE_PASS) |=> strobe_q);

    // R2: with a step below one half, carries are never back to back
    a_r2_frac_spaced: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (strobe_q && mode_q == MODE_FRAC && mode_nxt == MODE_FRAC) |=> !strobe_q);

endmodule

// File: rtl/fcd_out_stage.sv
module fcd_out_stage (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic strobe,
    input  logic gate_path,
    input  logic shift_path,
    output logic clk_out
);

    logic gate_q;
    logic shift_q;

    // Both registers move only while the reference is low, so the AND
    // below never sees its enable change during a high phase.
    always_ff @(negedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            gate_q  <= 1'b0;
            shift_q <= 1'b0;
        end else begin
            gate_q  <= strobe & gate_path;
            shift_q <= strobe & shift_path & ~gate_q;
        end
    end

    assign clk_out = (clk_ref & gate_q) | shift_q;

    // R3: shifted pulse lasts exactly one reference period
    a_r3_shift_one_period: assert property (@(negedge clk_ref) disable iff (!rst_n)
        shift_q |=> !shift_q);

    // R10: the two paths never drive at once, so no merged pulse
    a_r10_paths_exclusive: assert property (@(negedge clk_ref) disable iff (!rst_n)
        !(gate_q && shift_q));

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
    import fcd_pkg::*;
#(
    parameter int FRAC_W = 8
) (
    input  logic              clk_ref,
    input  logic              rst_n,
    input  logic              frac_en,
    input  logic [FRAC_W-1:0] div_step,
    output logic              clk_en,
    output logic              clk_out
);

    mode_e mode_nxt;
    mode_e mode_q;
    logic  gate_path;
    logic  shift_path;
    logic  strobe;

    fcd_mode_ctrl #(.FRAC_W(FRAC_W)) u_mode (
        .clk_ref   (clk_ref),
        .rst_n     (rst_n),
        .frac_en   (frac_en),
        .step      (div_step),
        .mode_nxt  (mode_nxt),
        .mode_q    (mode_q),
        .gate_path (gate_path),
        .shift_path(shift_path)
    );

    fcd_phase #(.FRAC_W(FRAC_W)) u_phase (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .mode_nxt(mode_nxt),
        .mode_q  (mode_q),
        .step    (div_step),
        .strobe  (strobe)
    );

    fcd_out_stage u_out (
        .clk_ref   (clk_ref),
        .rst_n     (rst_n),
        .strobe    (strobe),
        .gate_path (gate_path),
        .shift_path(shift_path),
        .clk_out   (clk_out)
    );

    assign clk_en = strobe;

    // R1: strobe is low on the first edge after reset release
    a_r1_quiet_after_reset: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (mode_q == MODE_HOLD) |-> !clk_en);

endmodule

// File: tb/tb_frac_clk_div.sv
`timescale 1ns/1ps
module tb_frac_clk_div;

    localparam int W    = 8;
    localparam int FULL = 1 << W;

    logic         clk_ref  = 1'b0;
    logic         rst_n    = 1'b0;
    logic         frac_en  = 1'b0;
    logic [W-1:0] div_step = '0;
    logic         clk_en;
    logic         clk_out;

    int n_chk  = 0;
    int n_fail = 0;
    int m_acc  = 0;
    int m_cnt  = 0;
    bit m_exp  = 1'b0;
    int en_cnt = 0;
    int rise_cnt = 0;
    bit done = 1'b0;

    bit      chk_w = 1'b0;
    realtime exp_w = 2.5;
    realtime t_rise = 0.0;
    string   w_tag = "R10";

    always #2.5 clk_ref = ~clk_ref;

    frac_clk_div #(.FRAC_W(W)) dut (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .frac_en (frac_en),
        .div_step(div_step),
        .clk_en  (clk_en),
        .clk_out (clk_out)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // clk_out pulse monitor
    always @(posedge clk_out) begin
        t_rise = $realtime;
        rise_cnt++;
    end

    always @(negedge clk_out) begin
        if (chk_w) begin
            realtime w;
            w = $realtime - t_rise;
            n_chk++;
            if (w < exp_w - 0.01 || w > exp_w + 0.01) begin
                n_fail++;
                $display("FAIL %s: pulse width actual %0.3f expected %0.3f", w_tag, w, exp_w);
            end
        end
    end

    // expected strobe for the next cycle, from the requirements
    task automatic model_step();
        int d = int'(div_step);
        if (!rst_n) begin
            m_acc = 0; m_cnt = 0; m_exp = 1'b0;
        end else if (!frac_en) begin
            m_acc = 0;
            if (d <= 1) begin
                m_cnt = 0; m_exp = 1'b1;
            end else if (m_cnt >= d - 1) begin
                m_cnt = 0; m_exp = 1'b1;
            end else begin
                m_cnt++; m_exp = 1'b0;
            end
        end else begin
            int s = m_acc + d;
            m_cnt = 0;
            m_exp = (s >= FULL);
            m_acc = s % FULL;
        end
    endtask

    task automatic tick(string tag);
        @(posedge clk_ref);
        model_step();
        #1;
        check(tag, int'(clk_en), int'(m_exp));
        en_cnt += int'(clk_en);
    endtask

    task automatic run(bit fe, int d, int n, string tag, string wt, realtime w, int exp_cnt);
        frac_en  = fe;
        div_step = W'(d);
        chk_w    = 1'b0;
        repeat (3) tick(tag);
        w_tag    = wt;
        exp_w    = w;
        en_cnt   = 0;
        rise_cnt = 0;
        chk_w    = 1'b1;
        repeat (n) tick(tag);
        chk_w    = 1'b0;
        check(tag, en_cnt, exp_cnt);
        check(tag, rise_cnt, exp_cnt);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) begin
            @(posedge clk_ref);
            #1;
            check("R1", int'(clk_en), 0);
            check("R1", int'(clk_out), 0);
            @(negedge clk_ref);
            #1;
            check("R1", int'(clk_out), 0);
        end
        @(posedge clk_ref);
        #1;
        m_acc = 0; m_cnt = 0; m_exp = 1'b0;
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd7151));
        frac_en  = 1'b1;
        div_step = 8'd96;
        do_reset();

        // R2 / R3: 3/8 step
        run(1'b1, 96, FULL, "R2", "R3", 5.0, 96);
        // R2: zero step gives nothing
        run(1'b1, 0, FULL, "R2", "R3", 5.0, 0);

        // R5: 4/3 ratio from reset, pattern 0,1,1,1
        frac_en  = 1'b1;
        div_step = 8'd192;
        do_reset();
        tick("R5"); tick("R5"); tick("R5"); tick("R5");
        run(1'b1, 192, FULL, "R5", "R10", 2.5, 192);

        // R4: other gated steps
        run(1'b1, 129, FULL, "R4", "R10", 2.5, 129);
        run(1'b1, 255, FULL, "R4", "R10", 2.5, 255);

        // R6 / R7
        run(1'b0, 5, 40, "R6", "R10", 2.5, 8);
        run(1'b0, 2, 16, "R6", "R10", 2.5, 8);
        run(1'b0, 1, 32, "R7", "R10", 2.5, 32);
        run(1'b0, 0, 32, "R7", "R10", 2.5, 32);

        // R8: integer mode leaves counter mid-way, accumulator must restart at zero
        frac_en  = 1'b0;
        div_step = 8'd7;
        repeat (4) tick("R6");
        frac_en  = 1'b1;
        div_step = 8'd64;
        for (int i = 0; i < 8; i++) tick("R8");

        // R9: step changes every few cycles
        for (int i = 0; i < 40; i++) begin
            div_step = W'($urandom_range(0, FULL / 2 - 1));
            repeat (1 + $urandom_range(0, 3)) tick("R9");
        end
        for (int i = 0; i < 40; i++) begin
            div_step = W'($urandom_range(FULL / 2, FULL - 1));
            repeat (1 + $urandom_range(0, 3)) tick("R9");
        end

        // random mix
        for (int i = 0; i < 24; i++) begin
            bit fe = 1'($urandom_range(0, 1));
            if (fe) begin
                int d = $urandom_range(0, FULL - 1);
                if (d >= FULL / 2) run(1'b1, d, FULL, "R4", "R10", 2.5, d);
                else               run(1'b1, d, FULL, "R2", "R3", 5.0, d);
            end else begin
                int d = $urandom_range(0, 30);
                if (d <= 1) run(1'b0, d, 32, "R7", "R10", 2.5, 32);
                else        run(1'b0, d, d * 4, "R6", "R10", 2.5, 4);
            end
        end

        // R1: reset asserted during a high output phase in bypass
        run(1'b0, 1, 8, "R7", "R10", 2.5, 8);
        @(posedge clk_ref);
        #1;
        check("R1", int'(clk_out), 1);
        rst_n = 1'b0;
        #0.5;
        check("R1", int'(clk_out), 0);
        check("R1", int'(clk_en), 0);
        do_reset();
        frac_en  = 1'b1;
        div_step = 8'd96;
        for (int i = 0; i < 16; i++) tick("R1");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule